// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O with Edge Interrupt

This block gives a host a small bank of general-purpose pins. Each pin can be an input or an output. The host programs five one-bit-per-pin control words through a plain port with an address, a read strobe and a write strobe. The control words are:

- direction;
- interrupt enable;
- output level;
- float (output disable);
- input inversion.

An output pin drives its stored level unless its float bit is set. An input pin is brought into the clock domain through a two-stage synchronizer. It is then optionally inverted, and its rising edge after inversion can raise a pending flag. All pending flags are ORed onto one interrupt line. With the inversion bit set, a falling pin edge is the one that counts.

A read of the level word has two effects. It returns the driven value for output pins and the conditioned input for input pins. It also acknowledges every pending interrupt at once.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset every control word is 0x00, `pin_oe` and `pin_out` are 0x00 and `irq` is 0.
- R2: Address 0 is direction (1 = output), 1 is interrupt enable, 3 is float and 4 is inversion. A write stores `wdata` in the next clock edge, a read with `rd` high returns the stored word combinationally, bit n belongs to pin n, and a control word changes only when it is written.
- R3: `pin_oe[n]` is 1 exactly when pin n is an output and its float bit is 0. `pin_out` always equals the stored level word (address 2).
- R4: A read of address 2 returns, per bit, the stored level for output pins and the synchronized input XOR its inversion bit for input pins. The synchronizer delays the input by two clock edges.
- R5: A 0-to-1 transition of (synchronized input XOR inversion bit) on an input pin with its enable bit set sets that pin's pending flag. A pin change driven before a clock edge shows on `irq` just after the third edge.
- R6: With the inversion bit set, a falling pin edge raises the interrupt and a rising edge does not. Setting the inversion bit of an enabled input that is low counts as an edge.
- R7: Output pins and pins with the enable bit at 0 never raise the interrupt. Clearing a pin's enable bit, or turning the pin into an output, drops that pin's pending flag one clock edge after the write takes effect.
- R8: A read strobe at address 2 clears all pending flags at the clock edge that ends it. A flag whose edge is detected at that same clock edge stays pending.
- R9: `irq` is the OR of all pending flags. Addresses 5 to 7 read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd` is high, else 0 |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq | output | 1 | Interrupt to host |

## Verification
Faults in the synchronizer or in the edge-history state appear at `irq` exactly one clock edge away from the expected third edge, so every edge check samples at a fixed cycle. A wrong inversion or direction bit shows up in the same read of the level word, or in `pin_oe`, directly after the write edge. A pending flag that is not cleared, or that is wrongly cleared, shows on `irq` right after the acknowledging read. A stale flag on a disabled pin shows one edge later. A cycle-accurate reference model in the bench checks these outputs on every clock, under random stimulus and under directed corner cases.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int NPINS_DEF  = 8;
    localparam int ADDR_W     = 3;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_DIR = 3'd0,
        A_IEN = 3'd1,
        A_LVL = 3'd2,
        A_FLT = 3'd3,
        A_INV = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      ien,
    output logic [W-1:0]      lvl,
    output logic [W-1:0]      flt,
    output logic [W-1:0]      inv
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] ien;
        logic [W-1:0] lvl;
        logic [W-1:0] flt;
        logic [W-1:0] inv;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr) begin
            case (addr)
                A_DIR:   ctl_d.dir = wdata;
                A_IEN:   ctl_d.ien = wdata;
                A_LVL:   ctl_d.lvl = wdata;
                A_FLT:   ctl_d.flt = wdata;
                A_INV:   ctl_d.inv = wdata;
                default: ctl_d = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign dir = ctl_q.dir;
    assign ien = ctl_q.ien;
    assign lvl = ctl_q.lvl;
    assign flt = ctl_q.flt;
    assign inv = ctl_q.inv;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] inv,
    input  logic [W-1:0] arm,
    input  logic         ack,
    output logic [W-1:0] view,
    output logic [W-1:0] hit,
    output logic [W-1:0] pend,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] pend;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        view      = sync_in ^ inv;
        hit       = view & ~st_q.prev & arm;
        st_d.prev = view;
        st_d.pend = ((ack ? '0 : st_q.pend) | hit) & arm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign irq  = |st_q.pend;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = NPINS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] r_dir, r_ien, r_lvl, r_flt, r_inv;
    logic [NPINS-1:0] s_in, e_view, e_hit, e_pend, e_arm;
    logic             lvl_ack;

    gpio_regs #(.W(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
        .dir(r_dir), .ien(r_ien), .lvl(r_lvl), .flt(r_flt), .inv(r_inv)
    );

    gpio_sync #(.W(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(s_in)
    );

    assign e_arm   = r_ien & ~r_dir;
    assign lvl_ack = rd && (addr == A_LVL);

    gpio_edge #(.W(NPINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_in(s_in), .inv(r_inv), .arm(e_arm),
        .ack(lvl_ack), .view(e_view), .hit(e_hit), .pend(e_pend), .irq(irq)
    );

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                A_DIR:   rdata = r_dir;
                A_IEN:   rdata = r_ien;
                A_LVL:   rdata = (r_dir & r_lvl) | (~r_dir & e_view);
                A_FLT:   rdata = r_flt;
                A_INV:   rdata = r_inv;
                default: rdata = '0;
            endcase
        end
    end

    assign pin_out = r_lvl;
    assign pin_oe  = r_dir & ~r_flt;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr,
    input logic         ack,
    input logic         irq,
    input logic [W-1:0] dir,
    input logic [W-1:0] ien,
    input logic [W-1:0] lvl,
    input logic [W-1:0] flt,
    input logic [W-1:0] inv,
    input logic [W-1:0] hit,
    input logic [W-1:0] pend,
    input logic [W-1:0] oe
);
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ((pend & $past(pend) & ~$past(hit)) == '0));

    assert_quiet_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(dir | ~ien)) == '0));

    assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit != '0));

    assert_regs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable({dir, ien, lvl, flt, inv}));

    assert_oe_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((oe & ~dir) == '0) && ((oe & flt) == '0));
endmodule

bind gpio_edge_irq gpio_irq_chk #(.W(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr(wr), .ack(lvl_ack), .irq(irq),
    .dir(r_dir), .ien(r_ien), .lvl(r_lvl), .flt(r_flt), .inv(r_inv),
    .hit(e_hit), .pend(e_pend), .oe(pin_oe)
);

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
    logic       irq;
    logic [7:0] pins = '0;
    int         checks = 0, errors = 0;
    logic       done = 1'b0;

    // reference state, built from the requirements
    logic [7:0] m_dir, m_ien, m_lvl, m_flt, m_inv, m_s1, m_s2, m_prev, m_pend;

    gpio_edge_irq u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0: return m_dir;
            3'd1: return m_ien;
            3'd2: return (m_dir & m_lvl) | (~m_dir & (m_s2 ^ m_inv));
            3'd3: return m_flt;
            3'd4: return m_inv;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] model_view();
        return m_s2 ^ m_inv;
    endfunction

    task automatic step(input logic r, input logic w, input logic [2:0] a,
                        input logic [7:0] d);
        logic [7:0] v, arm, hit;
        @(negedge clk);
        rd = r; wr = w; addr = a; wdata = d; pin_in = pins;
        #1;
        if (r) chk((a == 3'd2) ? "R4 level read" : "R2/R9 register read", rdata, exp_rdata(a));
        @(posedge clk);
        v = model_view();
        arm = m_ien & ~m_dir;
        hit = v & ~m_prev & arm;
        m_pend = (((r && a == 3'd2) ? 8'h00 : m_pend) | hit) & arm;
        m_prev = v;
        m_s2 = m_s1;
        m_s1 = pins;
        if (w) begin
            case (a)
                3'd0: m_dir = d;
                3'd1: m_ien = d;
                3'd2: m_lvl = d;
                3'd3: m_flt = d;
                3'd4: m_inv = d;
                default: ;
            endcase
        end
        #1;
        chk("R3 pin_oe", pin_oe, m_dir & ~m_flt);
        chk("R3 pin_out", pin_out, m_lvl);
        chk("R9 irq", irq, |m_pend);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 8'h00);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 2024;
        void'($urandom(seed));
        {m_dir, m_ien, m_lvl, m_flt, m_inv, m_s1, m_s2, m_prev, m_pend} = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 pin_oe at reset", pin_oe, 8'h00);
        chk("R1 pin_out at reset", pin_out, 8'h00);
        chk("R1 irq at reset", irq, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 8; a++) begin
            step(1'b1, 1'b0, 3'(a), 8'h00);
            chk("R1 register zero after reset", rdata, 8'h00);
        end

        // R3/R4 outputs, float, mixed readback
        step(1'b0, 1'b1, 3'd0, 8'hF0);
        step(1'b0, 1'b1, 3'd2, 8'hA5);
        step(1'b0, 1'b1, 3'd3, 8'h30);
        chk("R3 oe after float", pin_oe, 8'hC0);
        chk("R3 level drive", pin_out, 8'hA5);
        pins = 8'h0F;
        idle(3);
        step(1'b1, 1'b0, 3'd2, 8'h00);
        chk("R4 mixed level read", rdata, 8'hAF);
        pins = 8'h00;
        idle(3);
        step(1'b1, 1'b0, 3'd2, 8'h00);

        // R7 output pins never interrupt
        step(1'b0, 1'b1, 3'd1, 8'hFF);
        pins = 8'hF0;
        idle(4);
        chk("R7 output edge ignored", irq, 1'b0);

        // R5 rising edge latency: irq after third edge
        pins = 8'hF1;
        idle(2);
        chk("R5 irq not yet after two edges", irq, 1'b0);
        idle(1);
        chk("R5 irq after three edges", irq, 1'b1);
        step(1'b1, 1'b0, 3'd2, 8'h00);
        chk("R8 read clears irq", irq, 1'b0);

        // R6 inversion
        step(1'b0, 1'b1, 3'd4, 8'h02);
        chk("R6 inversion write edge pending next", irq, 1'b0);
        idle(1);
        chk("R6 inversion of low pin counts as edge", irq, 1'b1);
        step(1'b1, 1'b0, 3'd2, 8'h00);
        chk("R8 clear after inversion", irq, 1'b0);
        pins = 8'hF3;
        idle(4);
        chk("R6 rising pin ignored when inverted", irq, 1'b0);
        pins = 8'hF1;
        idle(3);
        chk("R6 falling pin raises irq when inverted", irq, 1'b1);

        // R8 edge coinciding with the acknowledging read survives
        pins = 8'hF0;
        idle(3);
        pins = 8'hF1;
        idle(2);
        step(1'b1, 1'b0, 3'd2, 8'h00);
        chk("R8 same-cycle edge stays pending", irq, 1'b1);
        step(1'b1, 1'b0, 3'd2, 8'h00);
        chk("R8 second read clears", irq, 1'b0);

        // R7 disabling drops a pending flag
        pins = 8'hF5;
        idle(3);
        chk("R5 pin2 edge", irq, 1'b1);
        step(1'b0, 1'b1, 3'd1, 8'hFB);
        idle(1);
        chk("R7 disable drops pending", irq, 1'b0);

        // R9 unused address
        step(1'b0, 1'b1, 3'd6, 8'hFF);
        step(1'b1, 1'b0, 3'd6, 8'h00);
        chk("R9 unused address reads zero", rdata, 8'h00);
        step(1'b1, 1'b0, 3'd0, 8'h00);
        chk("R9 unused write leaves direction", rdata, 8'hF0);

        // random phase against the reference model
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = $urandom % 10;
            if ($urandom % 3 == 0) pins = 8'($urandom);
            case (op)
                0, 1, 2, 3: idle(1);
                4, 5: step(1'b0, 1'b1, 3'($urandom % 8), 8'($urandom));
                6:    step(1'b0, 1'b1, 3'd0, 8'($urandom) & 8'h0F);
                7:    step(1'b1, 1'b0, 3'($urandom % 8), 8'h00);
                default: step(1'b1, 1'b0, 3'd2, 8'h00);
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule